// File: doc/BRIEF.md
# UART Interrupt Aggregator with Edge-Latched Sources

This block gathers the three interrupt sources of a UART into a single level-sensitive interrupt line. The sources are the receive queue reaching its fill trigger, the receive idle timeout, and the transmit queue dropping below its refill mark. Each source has a sticky pending flag. A flag is set only when its condition goes from false to true, never because the condition is simply true. A control register holds one enable per source. A status register shows the pending flags, and software clears them by writing ones to the flag positions.

Because the flags are edge-latched while the output is a level, a driver cannot rely on an interrupt firing just because it enabled the transmit source while the transmit queue was already low. It has to prime the queue itself, and the next new crossing of the mark then raises the interrupt. The receive fill condition is computed inside the block from the occupancy count of a 16-entry receive queue. The timeout and transmit conditions arrive as raw levels.

Each flag is a two-state machine. FLAG_IDLE moves to FLAG_PEND on a rising edge of the source condition (transition SET). FLAG_PEND moves back to FLAG_IDLE on a software clear when no rising edge occurs in the same cycle (transition CLEAR). In every other case the state holds (HOLD).

Top module: `uart_irq_agg`

## Requirements
- R1: `irq` is high exactly while at least one pending flag is set and the enable for that flag is set. `irq` is a combinational function of the flag and control registers.
- R2: A flag enters FLAG_PEND at the first clock edge where its condition is 1 and the registered copy of that condition is 0. This happens whether or not the flag's enable is set.
- R3: Once cleared, a flag is not set again by a condition that stays high. Only a new 0-to-1 transition sets it again.
- R4: Setting the transmit enable while `tx_below` is already high does not raise `irq`. A later low-then-high transition of `tx_below` does raise it.
- R5: The control register is at `reg_addr`=0. Its enable bits are: bit 9 for the receive timeout, bit 12 for the receive fill trigger, and bit 13 for the transmit mark.
- R6: The status register is at `reg_addr`=1. Its flag bits are: bit 4 for the receive fill trigger, bit 5 for the transmit mark, and bit 9 for the receive timeout. Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged. Writing 0x3F0 clears all three flags.
- R7: If a rising edge of a condition and a software clear of the same flag occur in the same cycle, the flag stays in FLAG_PEND.
- R8: The receive fill condition is true when `rx_count` is 8 or more, with `rx_count` ranging from 0 to 16.
- R9: Status bits other than 4, 5 and 9 read as 0. All 32 control bits are read/write storage that reads back the last value written.
- R10: A synchronous reset (`rst_n` low) clears the control register, all flags and the condition copies. `irq` then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_count | input | 5 | Receive queue occupancy, 0 to 16 |
| rx_tmo | input | 1 | Raw receive timeout condition |
| tx_below | input | 1 | Raw condition: transmit queue below its mark |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 selects the status register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default parameters: 32-bit registers, a 16-entry receive queue and a fill trigger of 8. With these values the trigger boundary between counts 7 and 8 is easy to hit, and random counts also reach the full value of 16. Random traffic on the three conditions, combined with random control writes and status clears, produces many coincidences of an edge with a clear. Directed sequences cover the primed-transmit case, the held-high condition after a clear, and the bulk clear with 0x3F0.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NSRC      = 3;
    localparam int SRC_RXTH  = 0;
    localparam int SRC_TX    = 1;
    localparam int SRC_RXTO  = 2;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;

    function automatic int ctl_pos(input int src);
        case (src)
            SRC_RXTH: return 12;
            SRC_TX:   return 13;
            default:  return 9;
        endcase
    endfunction

    function automatic int sts_pos(input int src);
        case (src)
            SRC_RXTH: return 4;
            SRC_TX:   return 5;
            default:  return 9;
        endcase
    endfunction
endpackage

// File: rtl/uirq_edge.sv
module uirq_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond,
    output logic [W-1:0] rise
);
    logic [W-1:0] cond_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= '0;
        else        cond_q <= cond;
    end

    assign rise = cond & ~cond_q;
endmodule

// File: rtl/uirq_flag.sv
module uirq_flag
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i) state_d = FLAG_PEND;
            FLAG_PEND: if (clr_i && !set_i) state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == FLAG_PEND);
    end
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
    import uirq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   pend,
    output logic [NSRC-1:0]   en,
    output logic [NSRC-1:0]   clr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_view;

    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl_q <= '0;
        else if (wr && addr == ADDR_CTRL) ctrl_q <= wdata;
    end

    always_comb begin
        stat_view = '0;
        for (int i = 0; i < NSRC; i++) begin
            stat_view[sts_pos(i)] = pend[i];
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign en[g]  = ctrl_q[ctl_pos(g)];
        assign clr[g] = wr && (addr == ADDR_STAT) && wdata[sts_pos(g)];
    end

    assign rdata = (addr == ADDR_STAT) ? stat_view : ctrl_q;
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
    import uirq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int RXQ_DEPTH = 16,
    parameter int RX_TRIG   = 8,
    localparam int CNT_W    = $clog2(RXQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_tmo,
    input  logic              tx_below,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [NSRC-1:0] cond_w;
    logic [NSRC-1:0] rise_w;
    logic [NSRC-1:0] clr_w;
    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] en_w;

    always_comb begin
        cond_w           = '0;
        cond_w[SRC_RXTH] = (32'(rx_count) >= RX_TRIG);
        cond_w[SRC_TX]   = tx_below;
        cond_w[SRC_RXTO] = rx_tmo;
    end

    uirq_edge #(.W(NSRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond_w),
        .rise  (rise_w)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        uirq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (rise_w[g]),
            .clr_i  (clr_w[g]),
            .pend_o (pend_w[g])
        );
    end

    uirq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .pend  (pend_w),
        .en    (en_w),
        .clr   (clr_w),
        .rdata (reg_rdata)
    );

    assign irq = |(pend_w & en_w);
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_below,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [2:0]        pend,
    input logic [2:0]        en
);
    // R1: an enabled pending transmit flag drives the line
    assert_tx_drives_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && en[1]) |-> irq);

    // R1: no pending flag, no interrupt
    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == 3'b000) |-> !irq);

    // R2: a rising transmit condition sets its flag
    assert_set_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_below) |-> ##0 1'b1 ##1 pend[1]);

    // R3: the transmit flag only appears with its condition high in the prior cycle
    assert_no_set_without_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[1]) |-> $past(tx_below));

    // R6: clearing with no rising condition drops the flag
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr && reg_wdata[5] && !tx_below) |=> !pend[1]);

    // R7: a simultaneous rise and clear keeps the flag
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_below) && reg_wr && reg_addr && reg_wdata[5]) |=> pend[1]);

    // R9: reserved status bits read zero
    assert_status_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr |-> ((reg_rdata & ~(DATA_W'(32'h0000_0230))) == '0));
endmodule

bind uart_irq_agg uirq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_below  (tx_below),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .pend      (pend_w),
    .en        (en_w)
);

// File: tb/tb_uart_irq_agg.sv
module tb_uart_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rx_count;
    logic        rx_tmo;
    logic        tx_below;
    logic        reg_wr;
    logic        reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2:0]  m_prev, m_pend;
    logic [31:0] m_ctrl;

    always #5 clk = ~clk;

    uart_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_tmo(rx_tmo),
        .tx_below(tx_below), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // index 0 fill trigger, 1 transmit mark, 2 receive timeout
    function automatic logic [2:0] en_of(input logic [31:0] c);
        return {c[9], c[13], c[12]};
    endfunction

    function automatic logic [31:0] sts_of(input logic [2:0] p);
        logic [31:0] r = '0;
        r[4] = p[0];
        r[5] = p[1];
        r[9] = p[2];
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [4:0] cnt, input logic tmo, input logic txb,
                         input logic wr, input logic addr, input logic [31:0] wd,
                         input string tag);
        logic [2:0] cond, rise, clr;
        logic       exp_irq;
        logic [31:0] exp_rd;
        @(negedge clk);
        rx_count = cnt; rx_tmo = tmo; tx_below = txb;
        reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        cond = {tmo, txb, (cnt >= 5'd8)};
        rise = cond & ~m_prev;
        clr  = (wr && addr) ? {wd[9], wd[5], wd[4]} : 3'b000;
        m_pend = rise | (m_pend & ~clr);
        if (wr && !addr) m_ctrl = wd;
        m_prev = cond;
        exp_irq = |(m_pend & en_of(m_ctrl));
        exp_rd  = addr ? sts_of(m_pend) : m_ctrl;
        @(posedge clk);
        #1;
        check(irq === exp_irq, {tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq});
        check(reg_rdata === exp_rd, {tag, " rdata"}, reg_rdata, exp_rd);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        rst_n = 1'b0; rx_count = '0; rx_tmo = 0; tx_below = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        m_prev = '0; m_pend = '0; m_ctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        cycle(0, 0, 0, 0, 1, 0, "R10 status");
        check(reg_rdata === 32'h0, "R10 status zero", reg_rdata, 0);
        cycle(0, 0, 0, 0, 0, 0, "R10 ctrl");
        check(irq === 1'b0, "R10 irq low", {31'b0, irq}, 0);

        // R9 control storage
        cycle(0, 0, 0, 1, 0, 32'hFFFF_FFFF, "R9 write ctrl");
        check(reg_rdata === 32'hFFFF_FFFF, "R9 ctrl readback", reg_rdata, 32'hFFFF_FFFF);
        cycle(0, 0, 0, 1, 0, 32'h0, "R9 clear ctrl");

        // R4 primed transmit: condition already high before enabling
        cycle(0, 0, 1, 0, 1, 0, "R4 tx rise");
        cycle(0, 0, 1, 1, 1, 32'h0000_03F0, "R6 bulk clear");
        cycle(0, 0, 1, 1, 0, 32'h0000_2000, "R4 enable tx");
        check(irq === 1'b0, "R4 no irq while held", {31'b0, irq}, 0);
        cycle(0, 0, 1, 0, 1, 0, "R3 held high");
        check(reg_rdata[5] === 1'b0, "R3 no reset of flag", reg_rdata, 0);
        cycle(0, 0, 0, 0, 1, 0, "R4 tx drop");
        cycle(0, 0, 1, 0, 1, 0, "R4 tx recross");
        check(irq === 1'b1 && reg_rdata[5], "R4 irq on new crossing", {31'b0, irq}, 1);

        // R6 writing zero keeps the flag
        cycle(0, 0, 1, 1, 1, 32'h0, "R6 zero write");
        check(reg_rdata[5] === 1'b1, "R6 flag kept", reg_rdata, 32'h20);

        // R7 rise and clear together
        cycle(0, 0, 0, 1, 1, 32'h20, "R7 drop and clear");
        cycle(0, 0, 1, 1, 1, 32'h20, "R7 rise with clear");
        check(reg_rdata[5] === 1'b1, "R7 set wins", reg_rdata, 32'h20);

        // R8 fill trigger boundary, R2 latch with enable off, R5 enable position
        cycle(0, 0, 1, 1, 0, 32'h0, "R5 disable all");
        cycle(7, 0, 1, 0, 1, 0, "R8 count 7");
        check(reg_rdata[4] === 1'b0, "R8 below trigger", reg_rdata, 0);
        cycle(8, 0, 1, 0, 1, 0, "R8 count 8");
        check(reg_rdata[4] === 1'b1 && irq === 1'b0, "R2 latch while disabled", reg_rdata, 32'h30);
        cycle(16, 1, 1, 0, 1, 0, "R2 timeout rise");
        check(reg_rdata === 32'h0000_0230, "R6 all flags", reg_rdata, 32'h230);
        cycle(16, 1, 1, 1, 0, 32'h0000_0200, "R5 timeout enable");
        check(irq === 1'b1, "R5 bit9 enables timeout", {31'b0, irq}, 1);
        cycle(16, 1, 1, 1, 0, 32'h0000_1000, "R5 fill enable");
        check(irq === 1'b1, "R5 bit12 enables fill", {31'b0, irq}, 1);
        cycle(16, 1, 1, 1, 1, 32'h0000_03F0, "R6 bulk clear all");
        check(reg_rdata === 32'h0 && irq === 1'b0, "R6 0x3F0 clears", reg_rdata, 0);

        // random traffic, R1 R2 R3 R6 R7 checked every cycle against the model
        seed = 32'd2024;
        void'($urandom(seed));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] w = $urandom;
            logic wr = (r[3:0] < 4'd5);
            logic ad = r[4];
            if (ad) w = w & 32'h0000_03F0;
            cycle(5'(r[31:8] % 17), r[5], r[6], wr, ad, w, "R1 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule